// File: doc/BRIEF.md
# Serial-Key Program/Verify Port for an 11-bit Program Store

This block is the test and programming access path of a small on-chip program store that holds 2K bytes. After each reset it listens to the reset pin as a serial input. The crystal clock strobes one bit per edge. When the first ten bits, least significant first, equal a parameterised key, the block enters the programming state. Any other value leaves it in normal operation until the next reset.

In the programming state, one 8-bit port supplies the store address in two halves. A select pin chooses which half is presented. With select low, the port gives the low byte. With select high, only the three low bits of the port are taken, as address bits 10 to 8. With the output-enable pin high the block is in verify mode and drives the addressed byte, read from a synchronous array, onto the data port. With output-enable low the data port is an input. A rising edge on the program-pulse pin latches that data and raises a one-cycle write strobe to the array.

Top module: `pgm_port_top`

## Requirements
- R1: While rstN is low, progActive, memWe and dataOe are 0, dataOut is 0 and memAddr is 0.
- R2: On the ten clock edges after rstN rises, keyIn is sampled one bit per edge, bit 0 first. If the collected value equals KEY_VALUE, progActive is 1 from the tenth edge on, until the next reset.
- R3: If the ten collected bits differ from KEY_VALUE, progActive stays 0 until the next reset. Bits that arrive on keyIn later are ignored.
- R4: In the programming state, an edge with selHigh low on both that edge and the previous edge loads addrPort into memAddr[7:0].
- R5: In the programming state, an edge with selHigh high on both that edge and the previous edge loads addrPort[2:0] into memAddr[10:8]. Port bits 7 to 3 are discarded.
- R6: An edge on which selHigh differs from its value at the previous edge changes no address bit.
- R7: With progActive and outEn both 1, dataOe is 1 and dataOut shows the array byte that the array read at memAddr on the previous edge.
- R8: With outEn 0, dataOe is 0 and dataOut is 0.
- R9: In the programming state with outEn 0, a rising edge of pgmPulse (1 now, 0 on the previous edge) latches dataIn into memWrData. memWe is then 1 for exactly the one following cycle. A pulse with outEn 1 writes nothing.
- R10: Outside the programming state, memAddr does not change, and memWe and dataOe stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; also strobes the key bits |
| rstN | input | 1 | Asynchronous active-low reset |
| keyIn | input | 1 | Reset-pin serial input carrying the entry key |
| selHigh | input | 1 | Address half select: 0 low byte, 1 high bits |
| outEn | input | 1 | 1 selects verify mode, 0 selects program mode |
| pgmPulse | input | 1 | Program pulse; its rising edge requests a write |
| addrPort | input | 8 | Multiplexed address port |
| dataIn | input | 8 | Data to program, valid with outEn 0 |
| dataOut | output | 8 | Verify data, 0 when not driving |
| dataOe | output | 1 | Output enable of the data port pad |
| memAddr | output | 11 | Address to the program store |
| memWrData | output | 8 | Write data to the program store |
| memWe | output | 1 | One-cycle write strobe to the program store |
| memRdData | input | 8 | Synchronous read data from the program store |
| progActive | output | 1 | 1 while the programming state is held |

## Verification
Some rules are checked on every cycle by the assertions. The mode never changes once the key window has closed. A write strobe never lasts two cycles. The write data and the low address byte hold unless their capture strobe fires. Outside the programming state the port stays quiet. Other behaviour only shows in the bench's scenarios. These are the key compare itself, the bit order, the select-stability gating of the two address halves, and a write that lands in the array and is then read back in verify mode. A per-cycle reference model checks the bench's stimulus patterns against them.

// File: rtl/pgm_port_pkg.sv
package pgm_port_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic captureLo;    // load low address byte from the port
    logic captureHi;    // load high address bits from the port
    logic captureData;  // latch program data and arm the write strobe
    logic driveOut;     // verify mode: drive read data onto the data port
  } pgmStrobes_t;

endpackage

// File: rtl/pgm_port_ctrl.sv
module pgm_port_ctrl
  import pgm_port_pkg::*;
#(
  parameter int KEY_BITS = 10,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = 10'h1B5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyIn,
  input  logic        selHigh,
  input  logic        outEn,
  input  logic        pgmPulse,
  output logic        progActive,
  output pgmStrobes_t strobes
);

  localparam int CNT_W = $clog2(KEY_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(KEY_BITS - 1);

  logic [KEY_BITS-1:0] keyShift;
  logic [KEY_BITS-1:0] keyNext;
  logic [CNT_W-1:0]    bitCnt;
  logic                keyDone;
  logic                selPrev;
  logic                pulsePrev;
  logic                selStable;
  logic                pulseRise;

  // New bits enter at the top, so after KEY_BITS shifts bit 0 holds the first one
  assign keyNext = {keyIn, keyShift[KEY_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyShift   <= '0;
      bitCnt     <= '0;
      keyDone    <= 1'b0;
      progActive <= 1'b0;
    end else if (!keyDone) begin
      keyShift <= keyNext;
      bitCnt   <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) begin
        keyDone    <= 1'b1;
        progActive <= (keyNext == KEY_VALUE);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev   <= 1'b0;
      pulsePrev <= 1'b0;
    end else begin
      selPrev   <= selHigh;
      pulsePrev <= pgmPulse;
    end
  end

  assign selStable = (selHigh == selPrev);
  assign pulseRise = pgmPulse & ~pulsePrev;

  always_comb begin
    strobes.captureLo   = progActive & selStable & ~selHigh;
    strobes.captureHi   = progActive & selStable &  selHigh;
    strobes.captureData = progActive & ~outEn & pulseRise;
    strobes.driveOut    = progActive & outEn;
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    keyDone |=> $stable(progActive)); // R3

  AST_NO_ENTRY_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    !keyDone |-> !progActive); // R2

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(KEY_BITS)); // R2

endmodule

// File: rtl/pgm_port_dp.sv
module pgm_port_dp
  import pgm_port_pkg::*;
#(
  parameter int PORT_BITS = 8,
  parameter int ADDR_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pgmStrobes_t          strobes,
  input  logic [PORT_BITS-1:0] addrPort,
  input  logic [PORT_BITS-1:0] dataIn,
  input  logic [PORT_BITS-1:0] memRdData,
  output logic [ADDR_BITS-1:0] memAddr,
  output logic [PORT_BITS-1:0] memWrData,
  output logic                 memWe,
  output logic [PORT_BITS-1:0] dataOut,
  output logic                 dataOe
);

  localparam int HI_BITS = ADDR_BITS - PORT_BITS;

  logic [PORT_BITS-1:0] addrLo;
  logic [HI_BITS-1:0]   addrHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
    end else begin
      if (strobes.captureLo) addrLo <= addrPort;
      if (strobes.captureHi) addrHi <= addrPort[HI_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrData <= '0;
      memWe     <= 1'b0;
    end else begin
      memWe <= strobes.captureData;
      if (strobes.captureData) memWrData <= dataIn;
    end
  end

  assign memAddr = {addrHi, addrLo};
  assign dataOe  = strobes.driveOut;
  assign dataOut = strobes.driveOut ? memRdData : '0;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R9

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureData |=> $stable(memWrData)); // R9

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureLo |=> $stable(memAddr[PORT_BITS-1:0])); // R4

endmodule

// File: rtl/pgm_port_top.sv
module pgm_port_top
  import pgm_port_pkg::*;
#(
  parameter int KEY_BITS = 10,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = 10'h1B5,
  parameter int PORT_BITS = 8,
  parameter int ADDR_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 keyIn,
  input  logic                 selHigh,
  input  logic                 outEn,
  input  logic                 pgmPulse,
  input  logic [PORT_BITS-1:0] addrPort,
  input  logic [PORT_BITS-1:0] dataIn,
  output logic [PORT_BITS-1:0] dataOut,
  output logic                 dataOe,
  output logic [ADDR_BITS-1:0] memAddr,
  output logic [PORT_BITS-1:0] memWrData,
  output logic                 memWe,
  input  logic [PORT_BITS-1:0] memRdData,
  output logic                 progActive
);

  pgmStrobes_t strobes;

  pgm_port_ctrl #(
    .KEY_BITS (KEY_BITS),
    .KEY_VALUE(KEY_VALUE)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .keyIn     (keyIn),
    .selHigh   (selHigh),
    .outEn     (outEn),
    .pgmPulse  (pgmPulse),
    .progActive(progActive),
    .strobes   (strobes)
  );

  pgm_port_dp #(
    .PORT_BITS(PORT_BITS),
    .ADDR_BITS(ADDR_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrPort (addrPort),
    .dataIn   (dataIn),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memWe    (memWe),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !progActive |-> (!dataOe && !memWe)); // R10

  AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !progActive |=> $stable(memAddr)); // R10

endmodule

// File: tb/pgm_port_top_tb_top.sv
module pgm_port_top_tb_top;

  localparam logic [9:0] KEY = 10'h1B5;
  localparam logic [9:0] BAD_KEY = 10'h1B4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyIn = 1'b0, selHigh = 1'b0, outEn = 1'b0, pgmPulse = 1'b0;
  logic [7:0]  addrPort = '0, dataIn = '0;
  logic [7:0]  dataOut, memWrData;
  logic [7:0]  memRdData = '0;
  logic [10:0] memAddr;
  logic        dataOe, memWe, progActive;

  logic [7:0] mem [0:2047];

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pgm_port_top #(.KEY_VALUE(KEY)) dut_i (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .selHigh(selHigh), .outEn(outEn),
    .pgmPulse(pgmPulse), .addrPort(addrPort), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .memAddr(memAddr),
    .memWrData(memWrData), .memWe(memWe), .memRdData(memRdData),
    .progActive(progActive)
  );

  function automatic logic [7:0] initByte(int a);
    return 8'((a * 37 + 11) ^ (a >> 4));
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Program store: synchronous read, read-before-write
  always @(posedge clk) begin
    memRdData <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWrData;
  end

  // Behavioural reference model
  int mBitIdx = 0, mKeyAcc = 0, mLo = 0, mHi = 0, mWd = 0, mRd = 0;
  bit mDone = 0, mAct = 0, mSelPrev = 0, mPulsePrev = 0, mWe = 0;
  int mMem [2048];

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i]  = initByte(i);
      mMem[i] = initByte(i);
    end
  end

  always @(posedge clk) begin
    int oldAddr, rdNew;
    bit rise, stable;
    cyc++;
    oldAddr = mHi * 256 + mLo;
    rdNew = mMem[oldAddr];
    if (mWe) mMem[oldAddr] = mWd;
    mRd = rdNew;
    if (!rstN) begin
      mBitIdx = 0; mKeyAcc = 0; mLo = 0; mHi = 0; mWd = 0;
      mDone = 0; mAct = 0; mSelPrev = 0; mPulsePrev = 0; mWe = 0;
    end else begin
      stable = (selHigh == mSelPrev);
      rise = pgmPulse && !mPulsePrev;
      mWe = mAct && !outEn && rise;
      if (mWe) mWd = dataIn;
      if (mAct && stable && !selHigh) mLo = addrPort;
      if (mAct && stable && selHigh) mHi = addrPort % 8;
      mSelPrev = selHigh;
      mPulsePrev = pgmPulse;
      if (!mDone) begin
        if (keyIn) mKeyAcc = mKeyAcc + (1 << mBitIdx);
        mBitIdx++;
        if (mBitIdx == 10) begin
          mDone = 1;
          mAct = (mKeyAcc == KEY);
        end
      end
    end
    #5;
    check("R2 progActive", progActive, mAct);
    check("R4 memAddr", memAddr, mHi * 256 + mLo);
    check("R9 memWe", memWe, mWe);
    check("R9 memWrData", memWrData, mWd);
    check("R8 dataOe", dataOe, mAct && outEn);
    check("R7 dataOut", dataOut, (mAct && outEn) ? mRd : 0);
    if (cyc > 20000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetAndKey(logic [9:0] k);
    @(negedge clk);
    rstN = 1'b0; selHigh = 0; outEn = 0; pgmPulse = 0; addrPort = 0; dataIn = 0;
    step(2);
    check("R1 progActive in reset", progActive, 0);
    check("R1 memWe in reset", memWe, 0);
    check("R1 dataOe in reset", dataOe, 0);
    check("R1 memAddr in reset", memAddr, 0);
    rstN = 1'b1;
    keyIn = k[0];
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      keyIn = k[i];
    end
    @(negedge clk);
    keyIn = 1'b0;
  endtask

  initial begin
    // Wrong key: stays in normal mode, later bits ignored
    resetAndKey(BAD_KEY);
    check("R3 mismatch keeps normal", progActive, 0);
    for (int i = 0; i < 10; i++) begin
      keyIn = KEY[i];
      @(negedge clk);
    end
    keyIn = 0;
    check("R3 late key ignored", progActive, 0);
    selHigh = 0; addrPort = 8'h44; outEn = 0; dataIn = 8'h11; pgmPulse = 1;
    step(2);
    check("R10 no address capture", memAddr, 0);
    check("R10 no write strobe", memWe, 0);
    outEn = 1;
    step(1);
    check("R10 no data drive", dataOe, 0);
    pgmPulse = 0; outEn = 0;

    // Correct key
    resetAndKey(KEY);
    check("R2 key match enters", progActive, 1);

    selHigh = 0; addrPort = 8'h34;
    step(2);
    check("R4 low byte", memAddr[7:0], 8'h34);
    selHigh = 1; addrPort = 8'hFD;
    step(2);
    check("R5 high bits only low three", memAddr, 11'h534);

    selHigh = 0; addrPort = 8'h99;
    step(1);
    check("R6 select change ignored", memAddr, 11'h534);
    selHigh = 1; addrPort = 8'hFA;
    step(1);
    check("R6 second change ignored", memAddr, 11'h534);
    step(1);
    check("R6 stable select captures", memAddr, 11'h234);
    addrPort = 8'hFD;
    step(1);
    check("R5 recapture", memAddr, 11'h534);

    // Program a byte
    outEn = 0; dataIn = 8'hA5; pgmPulse = 1;
    step(1);
    check("R9 strobe high", memWe, 1);
    check("R9 data latched", memWrData, 8'hA5);
    step(1);
    check("R9 strobe one cycle", memWe, 0);
    check("R9 array written", mem[11'h534], 8'hA5);
    pgmPulse = 0;
    step(1);

    // Verify
    outEn = 1;
    step(1);
    check("R7 verify drives", dataOe, 1);
    check("R7 verify written byte", dataOut, 8'hA5);
    selHigh = 0; addrPort = 8'h35;
    step(3);
    check("R7 verify new address", dataOut, initByte(11'h535));

    pgmPulse = 1;
    step(1);
    check("R9 no write in verify", memWe, 0);
    pgmPulse = 0;
    outEn = 0;
    step(1);
    check("R8 data port released", dataOe, 0);
    check("R8 data zero", dataOut, 0);

    dataIn = 8'h3C; pgmPulse = 1;
    step(2);
    pgmPulse = 0; outEn = 1;
    step(1);
    check("R9 second write read back", dataOut, 8'h3C);
    outEn = 0;
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule